// File: doc/BRIEF.md
# Bloom Address Signature Accumulator

This block gathers the addresses of one thread's retiring loads and stores into two Bloom-filter signatures, one for reads and one for writes. Each address is permuted and then hashed by several H3 hashes that run side by side. Each hash picks one bit in its own bank of the signature. A signature therefore over-approximates the set of touched addresses. An overlap test can give false alarms, but it never misses a true conflict.

The block keeps the thread's current timestamp. Two events close an epoch. The first is a synchronisation point (sync). The second is the end of a fixed-length block of dynamic instructions, counted while collection is on. On either event the block captures the timestamp and both signatures into a single dump slot, which a consumer drains with a valid/ready handshake. The live signatures start again from empty, and on a sync the timestamp then takes the new value offered with it.

A separate combinational port ANDs two signatures bit by bit and reports whether the result is empty. A conflict checker downstream uses this port.

Top module: `sig_accum`

## Requirements
- R1: After reset the dump slot is empty (`dump_valid` low), both live signatures are empty, the timestamp is 0 and collection is off, so accesses made before `collect_on` do not reach any signature.
- R2: A collected access sets exactly one bit per bank, in the read signature when `acc_is_write` is 0 and in the write signature when it is 1. Bank b occupies signature bits b*512 .. b*512+511. The bit set is at offset h, found as follows. The address is rotated left by 5 bits and XORed with 0xA5C30F69. h is the XOR, over every set bit r of that permuted word, of key(b,r) = ((r+1)*(2b+3)*97 + 55b) mod 512. Re-inserting an address already present changes nothing.
- R3: A `collect_on` pulse enables collection from the next cycle and a `collect_off` pulse disables it. When both arrive in the same cycle, off wins. While collection is off, accesses leave both signatures unchanged.
- R4: A `sync_reached` pulse dumps the timestamp held before the pulse, with cause 0, and clears both live signatures. The timestamp then becomes `ts_new`. The dump is visible one clock after the pulse when the slot is free.
- R5: The 2000th `insn_retire` pulse counted while collection is on produces a dump with cause 1 and leaves the timestamp unchanged. Counting restarts after every sync or block end. Pulses that arrive while collection is off are not counted.
- R6: While `dump_valid` is high and `dump_ready` is low, every dump output holds steady. A dump is consumed on a cycle where both are high.
- R7: An access in the same cycle as a dump trigger, or after it, goes into the new cleared signature and never into the dumped one. This holds even while the dump waits for `dump_ready`.
- R8: A trigger that arrives while the slot is still occupied is held. Later accesses keep joining the live signatures. In the first cycle the slot frees, the held dump is loaded. It carries the timestamp from the moment of the held trigger, and cause 0 if any merged trigger was a sync.
- R9: `isect` equals `cmp_a & cmp_b` combinationally, and `isect_empty` is high exactly when every bit of `isect` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| collect_on | input | 1 | Pulse: enable address collection |
| collect_off | input | 1 | Pulse: disable address collection (wins over on) |
| acc_valid | input | 1 | A memory access retires this cycle |
| acc_is_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W (32) | Address of the retiring access |
| insn_retire | input | 1 | One dynamic instruction retires this cycle |
| sync_reached | input | 1 | Pulse: thread reached a sync point |
| ts_new | input | TS_W (16) | Timestamp taken after a sync dump |
| dump_valid | output | 1 | Dump slot holds a record |
| dump_ready | input | 1 | Consumer accepts the record |
| dump_cause | output | 1 | 0 = sync, 1 = instruction block end |
| dump_ts | output | TS_W (16) | Timestamp of the dumped epoch |
| dump_rsig | output | SIG_W (2048) | Dumped read signature |
| dump_wsig | output | SIG_W (2048) | Dumped write signature |
| cmp_a | input | SIG_W (2048) | First operand of the intersection |
| cmp_b | input | SIG_W (2048) | Second operand of the intersection |
| isect | output | SIG_W (2048) | Bitwise AND of the operands |
| isect_empty | output | 1 | High when the intersection is all zero |

## Verification
A wrong hash key or permutation shows in the first dump after a sync. The dumped bits sit at positions other than those the independent model predicts, and the bench compares every one of the 2048 bits of each signature. A signature register that fails to clear, or that loads at the wrong moment, leaks an address into the neighbouring dump. This becomes visible one handshake later, and the stalled-slot sequence is built so that each of its three dumps holds a different, known set. An instruction counter that is off by one shows within a single block, because the bench samples `dump_valid` just before and just after the 2000th counted pulse.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;

  typedef enum logic {
    CAUSE_SYNC  = 1'b0,
    CAUSE_BLOCK = 1'b1
  } cause_e;

  // One H3 key row: a fixed constant derived from bank and row number.
  function automatic logic [15:0] h3_key(input int bank, input int row, input int idx_w);
    int v;
    v = (row + 1) * (2 * bank + 3) * 97 + 55 * bank;
    return 16'(v) & 16'((1 << idx_w) - 1);
  endfunction

  // Bijective address scramble: rotate left by rot, then XOR with mask.
  function automatic logic [63:0] permute_addr(input logic [63:0] a, input int aw,
                                               input int rot, input logic [63:0] mask);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < aw) r[(i + rot) % aw] = a[i];
    end
    return r ^ mask;
  endfunction

  // H3 hash: XOR of the key rows selected by set address bits.
  function automatic logic [15:0] h3_index(input logic [63:0] p, input int aw,
                                           input int bank, input int idx_w);
    logic [15:0] h;
    h = '0;
    for (int r = 0; r < 64; r++) begin
      if (r < aw && p[r]) h = h ^ h3_key(bank, r, idx_w);
    end
    return h;
  endfunction

endpackage

// File: rtl/sig_hash_lane.sv
module sig_hash_lane #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 9,
  parameter int BANK   = 0,
  localparam int BANK_W = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0] perm_addr,
  output logic [BANK_W-1:0] hit
);
  import sigacc_pkg::*;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = IDX_W'(h3_index(64'(perm_addr), ADDR_W, BANK, IDX_W));
    hit = '0;
    hit[idx] = 1'b1;
  end
endmodule

// File: rtl/sig_epoch_ctl.sv
module sig_epoch_ctl #(
  parameter int TS_W      = 16,
  parameter int BLOCK_LEN = 2000,
  localparam int CNT_W    = $clog2(BLOCK_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            collect_on,
  input  logic            collect_off,
  input  logic            insn_retire,
  input  logic            sync_reached,
  input  logic [TS_W-1:0] ts_new,
  input  logic            slot_free,
  output logic            collecting,
  output logic            fire,
  output logic [TS_W-1:0] fire_ts,
  output logic            fire_cause,
  output logic            pend_q,
  output logic [TS_W-1:0] cur_ts,
  output logic [CNT_W-1:0] blk_cnt
);
  import sigacc_pkg::*;

  logic            count_en;
  logic            blk_end;
  logic            trig;
  cause_e          cause_now;
  cause_e          pend_cause;
  logic [TS_W-1:0] pend_ts;

  always_comb begin
    count_en  = collecting & insn_retire;
    blk_end   = count_en && (blk_cnt == CNT_W'(BLOCK_LEN - 1));
    trig      = sync_reached | blk_end;
    cause_now = sync_reached ? CAUSE_SYNC : CAUSE_BLOCK;
    fire      = (trig | pend_q) & slot_free;
    fire_ts   = pend_q ? pend_ts : cur_ts;
    if (pend_q)
      fire_cause = pend_cause & (trig ? cause_now : 1'b1);
    else
      fire_cause = cause_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      cur_ts     <= '0;
      blk_cnt    <= '0;
      pend_q     <= 1'b0;
      pend_ts    <= '0;
      pend_cause <= CAUSE_SYNC;
    end else begin
      if (collect_off)      collecting <= 1'b0;
      else if (collect_on)  collecting <= 1'b1;

      if (sync_reached) cur_ts <= ts_new;

      if (trig)          blk_cnt <= '0;
      else if (count_en) blk_cnt <= blk_cnt + 1'b1;

      if (fire)      pend_q <= 1'b0;
      else if (trig) pend_q <= 1'b1;

      if (trig && !fire) begin
        if (!pend_q) begin
          pend_ts    <= cur_ts;
          pend_cause <= cause_now;
        end else begin
          pend_cause <= cause_e'(pend_cause & cause_now);
        end
      end
    end
  end
endmodule

// File: rtl/sig_dump_slot.sv
module sig_dump_slot #(
  parameter int TS_W  = 16,
  parameter int SIG_W = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TS_W-1:0]  in_ts,
  input  logic             in_cause,
  input  logic [SIG_W-1:0] in_rsig,
  input  logic [SIG_W-1:0] in_wsig,
  input  logic             dump_ready,
  output logic             slot_free,
  output logic             dump_valid,
  output logic [TS_W-1:0]  dump_ts,
  output logic             dump_cause,
  output logic [SIG_W-1:0] dump_rsig,
  output logic [SIG_W-1:0] dump_wsig
);
  assign slot_free = !dump_valid || dump_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dump_valid <= 1'b0;
      dump_ts    <= '0;
      dump_cause <= 1'b0;
      dump_rsig  <= '0;
      dump_wsig  <= '0;
    end else if (load) begin
      dump_valid <= 1'b1;
      dump_ts    <= in_ts;
      dump_cause <= in_cause;
      dump_rsig  <= in_rsig;
      dump_wsig  <= in_wsig;
    end else if (dump_ready) begin
      dump_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_isect.sv
module sig_isect #(
  parameter int N_BANKS = 4,
  parameter int BANK_W  = 512,
  localparam int SIG_W  = N_BANKS * BANK_W
) (
  input  logic [SIG_W-1:0] a,
  input  logic [SIG_W-1:0] b,
  output logic [SIG_W-1:0] y,
  output logic             empty
);
  logic [N_BANKS-1:0] bank_any;

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    assign y[k*BANK_W +: BANK_W] = a[k*BANK_W +: BANK_W] & b[k*BANK_W +: BANK_W];
    assign bank_any[k] = |y[k*BANK_W +: BANK_W];
  end

  assign empty = ~|bank_any;
endmodule

// File: rtl/sig_accum.sv
module sig_accum #(
  parameter int ADDR_W                 = 32,
  parameter int N_BANKS                = 4,
  parameter int IDX_W                  = 9,
  parameter int TS_W                   = 16,
  parameter int BLOCK_LEN              = 2000,
  parameter int PERM_ROT               = 5,
  parameter logic [ADDR_W-1:0] PERM_MASK = 32'hA5C3_0F69,
  localparam int BANK_W                = 1 << IDX_W,
  localparam int SIG_W                 = N_BANKS * BANK_W,
  localparam int CNT_W                 = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              collect_on,
  input  logic              collect_off,
  input  logic              acc_valid,
  input  logic              acc_is_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              insn_retire,
  input  logic              sync_reached,
  input  logic [TS_W-1:0]   ts_new,
  output logic              dump_valid,
  input  logic              dump_ready,
  output logic              dump_cause,
  output logic [TS_W-1:0]   dump_ts,
  output logic [SIG_W-1:0]  dump_rsig,
  output logic [SIG_W-1:0]  dump_wsig,
  input  logic [SIG_W-1:0]  cmp_a,
  input  logic [SIG_W-1:0]  cmp_b,
  output logic [SIG_W-1:0]  isect,
  output logic              isect_empty
);
  import sigacc_pkg::*;

  logic [ADDR_W-1:0] perm_addr;
  logic [SIG_W-1:0]  hit;
  logic [SIG_W-1:0]  rd_hit, wr_hit;
  logic [SIG_W-1:0]  live_r, live_w;
  logic              collecting, fire, fire_cause, pend_q, slot_free;
  logic [TS_W-1:0]   fire_ts, cur_ts;
  logic [CNT_W-1:0]  blk_cnt;

  assign perm_addr = ADDR_W'(permute_addr(64'(acc_addr), ADDR_W, PERM_ROT, 64'(PERM_MASK)));

  for (genvar b = 0; b < N_BANKS; b++) begin : g_lane
    sig_hash_lane #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK(b)) u_lane (
      .perm_addr(perm_addr),
      .hit      (hit[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rd_hit = (acc_valid && collecting && !acc_is_write) ? hit : '0;
    wr_hit = (acc_valid && collecting &&  acc_is_write) ? hit : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_r <= '0;
      live_w <= '0;
    end else begin
      live_r <= (fire ? '0 : live_r) | rd_hit;
      live_w <= (fire ? '0 : live_w) | wr_hit;
    end
  end

  sig_epoch_ctl #(.TS_W(TS_W), .BLOCK_LEN(BLOCK_LEN)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .collect_on  (collect_on),
    .collect_off (collect_off),
    .insn_retire (insn_retire),
    .sync_reached(sync_reached),
    .ts_new      (ts_new),
    .slot_free   (slot_free),
    .collecting  (collecting),
    .fire        (fire),
    .fire_ts     (fire_ts),
    .fire_cause  (fire_cause),
    .pend_q      (pend_q),
    .cur_ts      (cur_ts),
    .blk_cnt     (blk_cnt)
  );

  sig_dump_slot #(.TS_W(TS_W), .SIG_W(SIG_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .in_ts     (fire_ts),
    .in_cause  (fire_cause),
    .in_rsig   (live_r),
    .in_wsig   (live_w),
    .dump_ready(dump_ready),
    .slot_free (slot_free),
    .dump_valid(dump_valid),
    .dump_ts   (dump_ts),
    .dump_cause(dump_cause),
    .dump_rsig (dump_rsig),
    .dump_wsig (dump_wsig)
  );

  sig_isect #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_isect (
    .a    (cmp_a),
    .b    (cmp_b),
    .y    (isect),
    .empty(isect_empty)
  );
endmodule

// File: rtl/sig_accum_chk.sv
module sig_accum_chk #(
  parameter int N_BANKS   = 4,
  parameter int TS_W      = 16,
  parameter int SIG_W     = 2048,
  parameter int BLOCK_LEN = 2000,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dump_valid,
  input logic             dump_ready,
  input logic             dump_cause,
  input logic [TS_W-1:0]  dump_ts,
  input logic [SIG_W-1:0] dump_rsig,
  input logic [SIG_W-1:0] dump_wsig,
  input logic [SIG_W-1:0] cmp_a,
  input logic [SIG_W-1:0] cmp_b,
  input logic             isect_empty,
  input logic             fire,
  input logic             collecting,
  input logic             pend_q,
  input logic [SIG_W-1:0] live_r,
  input logic [SIG_W-1:0] live_w,
  input logic [TS_W-1:0]  cur_ts,
  input logic [CNT_W-1:0] blk_cnt,
  input logic             sync_reached,
  input logic [TS_W-1:0]  ts_new
);
  // R6: stalled record must not move
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid && !dump_ready |=> dump_valid && $stable(dump_ts) && $stable(dump_cause)
                                  && $stable(dump_rsig) && $stable(dump_wsig));

  // R7: right after a dump trigger each live signature holds at most one access
  a_r7_fresh_sig: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($countones(live_r) <= N_BANKS) && ($countones(live_w) <= N_BANKS));

  // R3: collection off and no dump means signatures frozen
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !collecting && !fire |=> $stable(live_r) && $stable(live_w));

  // R4: timestamp follows ts_new after a sync
  a_r4_ts_update: assert property (@(posedge clk) disable iff (!rst_n)
    sync_reached |=> cur_ts == $past(ts_new));

  // R4: a direct dump carries the timestamp held before the trigger
  a_r4_dump_ts: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !pend_q |=> dump_valid && dump_ts == $past(cur_ts));

  // R5: block counter never reaches the block length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt < CNT_W'(BLOCK_LEN));

  // R8: a held trigger exists only while the slot is occupied
  a_r8_pend_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> dump_valid);

  // R9: emptiness flag against the operand ports
  always_comb begin
    if (rst_n) begin
      a_r9_empty_flag: assert (isect_empty == ((cmp_a & cmp_b) == '0));
    end
  end
endmodule

bind sig_accum sig_accum_chk #(
  .N_BANKS(N_BANKS), .TS_W(TS_W), .SIG_W(SIG_W), .BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dump_valid(dump_valid), .dump_ready(dump_ready),
  .dump_cause(dump_cause), .dump_ts(dump_ts), .dump_rsig(dump_rsig), .dump_wsig(dump_wsig),
  .cmp_a(cmp_a), .cmp_b(cmp_b), .isect_empty(isect_empty), .fire(fire),
  .collecting(collecting), .pend_q(pend_q), .live_r(live_r), .live_w(live_w),
  .cur_ts(cur_ts), .blk_cnt(blk_cnt), .sync_reached(sync_reached), .ts_new(ts_new)
);

// File: tb/sim_sig_accum.sv
`timescale 1ns/1ps
module sim_sig_accum;
  localparam int SIG_W = 2048;
  localparam int TS_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic collect_on = 0, collect_off = 0, acc_valid = 0, acc_is_write = 0;
  logic [31:0] acc_addr = '0;
  logic insn_retire = 0, sync_reached = 0, dump_ready = 0;
  logic [TS_W-1:0] ts_new = '0;
  logic dump_valid, dump_cause, isect_empty;
  logic [TS_W-1:0] dump_ts;
  logic [SIG_W-1:0] dump_rsig, dump_wsig, isect;
  logic [SIG_W-1:0] cmp_a = '0, cmp_b = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sig_accum u0 (
    .clk(clk), .rst_n(rst_n), .collect_on(collect_on), .collect_off(collect_off),
    .acc_valid(acc_valid), .acc_is_write(acc_is_write), .acc_addr(acc_addr),
    .insn_retire(insn_retire), .sync_reached(sync_reached), .ts_new(ts_new),
    .dump_valid(dump_valid), .dump_ready(dump_ready), .dump_cause(dump_cause),
    .dump_ts(dump_ts), .dump_rsig(dump_rsig), .dump_wsig(dump_wsig),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .isect(isect), .isect_empty(isect_empty)
  );

  // stimulus table: {is_write, address}
  localparam logic [32:0] VECS [0:7] = '{
    {1'b0, 32'h0000_0000}, {1'b1, 32'hFFFF_FFFF}, {1'b0, 32'h1000_0040},
    {1'b0, 32'h1000_0044}, {1'b1, 32'h1000_0040}, {1'b1, 32'h8000_0001},
    {1'b0, 32'h1000_0040}, {1'b1, 32'h0BAD_F00D}
  };

  // independent signature model following R2
  function automatic logic [SIG_W-1:0] model_bits(input logic [31:0] a);
    logic [31:0] p;
    logic [SIG_W-1:0] s;
    p = {a[26:0], a[31:27]} ^ 32'hA5C3_0F69;
    s = '0;
    for (int b = 0; b < 4; b++) begin
      int h;
      h = 0;
      for (int r = 0; r < 32; r++) begin
        if (p[r]) h = h ^ ((97 * (r + 1) * (3 + 2 * b) + b * 55) % 512);
      end
      s[b * 512 + h] = 1'b1;
    end
    return s;
  endfunction

  task automatic chk_num(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_sig(input string req, input string what, input logic [SIG_W-1:0] act,
                         input logic [SIG_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w);
    acc_valid = 1; acc_addr = a; acc_is_write = w;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic do_sync(input logic [TS_W-1:0] t);
    sync_reached = 1; ts_new = t;
    @(negedge clk);
    sync_reached = 0;
  endtask

  task automatic accept();
    dump_ready = 1;
    @(negedge clk);
    dump_ready = 0;
  endtask

  task automatic pulse_on();
    collect_on = 1; @(negedge clk); collect_on = 0;
  endtask

  task automatic pulse_off();
    collect_off = 1; @(negedge clk); collect_off = 0;
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) begin
      insn_retire = 1; @(negedge clk);
    end
    insn_retire = 0;
  endtask

  task automatic chk_dump(input string req, input logic [TS_W-1:0] ts, input logic cause,
                          input logic [SIG_W-1:0] rs, input logic [SIG_W-1:0] ws);
    chk_num(req, "dump_valid", 64'(dump_valid), 64'd1);
    chk_num(req, "dump_ts", 64'(dump_ts), 64'(ts));
    chk_num(req, "dump_cause", 64'(dump_cause), 64'(cause));
    chk_sig(req, "dump_rsig", dump_rsig, rs);
    chk_sig(req, "dump_wsig", dump_wsig, ws);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [SIG_W-1:0] er, ew, sa, sb, sc, sd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_num("R1", "dump_valid after reset", 64'(dump_valid), 64'd0);
    chk_num("R1", "isect_empty on zero operands", 64'(isect_empty), 64'd1);

    // R1/R3 access before collect_on must not be recorded
    access(32'h7777_0000, 1'b1);
    pulse_on();

    // table walk, R2
    er = '0; ew = '0;
    for (int i = 0; i < 8; i++) begin
      access(VECS[i][31:0], VECS[i][32]);
      if (VECS[i][32]) ew |= model_bits(VECS[i][31:0]);
      else             er |= model_bits(VECS[i][31:0]);
    end
    do_sync(16'd5);
    chk_dump("R2", 16'd0, 1'b0, er, ew);
    accept();
    chk_num("R6", "dump_valid after accept", 64'(dump_valid), 64'd0);

    // R4: signatures cleared, timestamp updated
    do_sync(16'd7);
    chk_dump("R4", 16'd5, 1'b0, '0, '0);
    accept();

    // R3: simultaneous on/off -> off wins, access ignored
    collect_on = 1; collect_off = 1; @(negedge clk); collect_on = 0; collect_off = 0;
    access(32'h1234_5678, 1'b0);
    do_sync(16'd8);
    chk_dump("R3", 16'd7, 1'b0, '0, '0);
    accept();

    // R7/R8: stalled dump, same-cycle access and held trigger
    pulse_on();
    sa = model_bits(32'h0000_1000);
    sb = model_bits(32'h0000_2000);
    sc = model_bits(32'h0000_3000);
    sd = model_bits(32'h0000_4000);
    access(32'h0000_1000, 1'b0);                 // A read
    acc_valid = 1; acc_addr = 32'h0000_2000; acc_is_write = 1;  // B write same cycle
    do_sync(16'd9);
    acc_valid = 0;
    chk_dump("R7", 16'd8, 1'b0, sa, '0);
    access(32'h0000_3000, 1'b0);                 // C read while stalled
    do_sync(16'd12);                             // held trigger
    access(32'h0000_4000, 1'b1);                 // D write after held trigger
    chk_dump("R6", 16'd8, 1'b0, sa, '0);
    accept();
    chk_dump("R8", 16'd9, 1'b0, sc, sb | sd);
    accept();
    do_sync(16'd15);
    chk_dump("R8", 16'd12, 1'b0, '0, '0);
    accept();

    // R5: block end, counting only while collecting
    pulse_off();
    retire(5);
    pulse_on();
    access(32'hCAFE_0000, 1'b1);
    retire(1999);
    chk_num("R5", "no dump before 2000th counted insn", 64'(dump_valid), 64'd0);
    retire(1);
    chk_dump("R5", 16'd15, 1'b1, '0, model_bits(32'hCAFE_0000));
    accept();

    // R9 intersection
    cmp_a = sa; cmp_b = '0; #1;
    chk_num("R9", "empty vs zero operand", 64'(isect_empty), 64'd1);
    cmp_b = sa | sb; #1;
    chk_sig("R9", "isect overlap", isect, sa);
    chk_num("R9", "empty on overlap", 64'(isect_empty), 64'd0);
    cmp_a = '0; cmp_a[SIG_W-1] = 1'b1; cmp_b = '0; cmp_b[SIG_W-1] = 1'b1; cmp_b[0] = 1'b1; #1;
    chk_num("R9", "single top-bit overlap empty", 64'(isect_empty), 64'd0);
    chk_sig("R9", "single top-bit overlap", isect, cmp_a);
    cmp_a = '0; cmp_a[0] = 1'b1; cmp_b = '0; cmp_b[1] = 1'b1; #1;
    chk_num("R9", "adjacent bits disjoint", 64'(isect_empty), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule